// File: doc/BRIEF.md
# Grouped Pin Interrupt Aggregator

This block turns per-pin input levels into latched interrupt events and sorts them into a small number of interrupt groups. Each pin has a three-bit trigger mode and a three-bit group index. Both come from the pin configuration storage next to the block. A pin whose mode detects an event sets its own pending flag. That flag is shown only in the status words of the group the pin is routed to right now, and it drives only that group's interrupt line.

Software reaches the pending flags through a byte-addressed status window. Every group owns a 64-byte slice of the window, holding one 32-bit word per 32 pins. Reads return the pending bits of the pins currently routed to that group. Writing a one to a bit acknowledges and clears that pin's flag.

Top module: `irq_group_aggregator`

## Requirements
- R1: While reset is applied, and until the internal reset is released two clock edges after `rst_n` rises, every pending flag is clear, every `irq_line` bit is 0 and `bus_rdata` is 0.
- R2: The status word for group g and pin p is at byte address 0x800 + 0x40·g + 4·(p>>5). Pin p occupies bit p mod 32 of that word.
- R3: Mode 2 (level high) sets the pin's pending flag on every clock edge at which the level is 1. Mode 3 (level low) does the same when the level is 0. The flag stays set after the condition ends, until it is cleared.
- R4: Mode 4 latches a 0→1 change of the level, mode 5 a 1→0 change, and mode 6 either change. The change is measured against the level sampled at the previous edge. The flag is held until it is cleared.
- R5: Modes 0, 1 and 7 produce no new event, with mode 7 serving as the pin's mask. A pin whose group index is not below NGROUPS also produces no event. A flag that is already set is kept in all these cases.
- R6: A write with `bus_wr` high to a mapped status word clears the flags of the pins whose bit in `bus_wdata` is 1 and that are currently routed to the addressed group. Zero bits leave flags unchanged.
- R7: If a pin detects an event at the same edge as a write-one-to-clear of its bit, its flag is set after that edge.
- R8: `irq_line[g]` is 1 exactly when at least one pin currently routed to group g has its flag set.
- R9: Reads at addresses outside the mapped words return 0. Unmapped means below 0x800, a group not below NGROUPS, a word index not below ceil(NPINS/32), or an address that is not word aligned. Bits for pin positions not below NPINS also read as 0. Writes to unmapped addresses change nothing.
- R10: `bus_rdata` is registered. It takes the addressed word, as it stood before the edge, at the edge where `bus_rd` is high, and it holds its value while `bus_rd` is low.
- R11: A pending flag belongs to the pin, not to the group. When a pin's group index changes, its set flag moves at once to the new group's status word and interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NPINS | Synchronous level of each pin |
| pin_mode | input | 3·NPINS | Trigger mode of pin p in bits [3p+2:3p] |
| pin_group | input | 3·NPINS | Group index of pin p in bits [3p+2:3p] |
| bus_wr | input | 1 | Write strobe, write-one-to-clear |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address in the status window |
| bus_wdata | input | 32 | Write data, one bit per pin of the word |
| bus_rdata | output | 32 | Registered read data |
| irq_line | output | NGROUPS | One interrupt line per group |

## Verification
The assertions assume that `pin_level` is already synchronous to `clk` and changes only between edges. They also assume the pins are low when the internal reset is released, so that no false rising edge appears against the reset value of the sampled level. The bench holds all pins low through reset and drives every input just after the falling clock edge. It models the flags as plain per-pin bits and checks the interrupt lines and read data at every cycle. That covers directed cases for each mode, a clear colliding with a new event, regrouping of a set flag, and unmapped addresses, followed by random modes, groups (unused groups included), levels and bus traffic.

// File: rtl/gia_pkg.sv
package gia_pkg;

  typedef enum logic [2:0] {
    PM_IDLE   = 3'd0,
    PM_DRIVE  = 3'd1,
    PM_HIGH   = 3'd2,
    PM_LOW    = 3'd3,
    PM_RISE   = 3'd4,
    PM_FALL   = 3'd5,
    PM_BOTH   = 3'd6,
    PM_MASKED = 3'd7
  } pin_mode_e;

  localparam int GRP_W       = 3;
  localparam int WORD_IDX_W  = 4;
  localparam int GRP_BYTES   = 64;

endpackage

// File: rtl/gia_pin_cell.sv
module gia_pin_cell
  import gia_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  logic [2:0] mode,
  input  logic       route_ok,
  input  logic       clr,
  output logic       pend
);

  logic lvl_q;
  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic evt;

  // event detection against the level seen at the previous edge
  always_comb begin
    evt = 1'b0;
    unique case (pin_mode_e'(mode))
      PM_HIGH: evt = lvl;
      PM_LOW:  evt = ~lvl;
      PM_RISE: evt = lvl & ~lvl_q;
      PM_FALL: evt = ~lvl & lvl_q;
      PM_BOTH: evt = lvl ^ lvl_q;
      default: evt = 1'b0;
    endcase
    evt = evt & route_ok;
  end

  // set dominates clear
  always_comb begin
    pend_en = evt | clr;
    pend_d  = evt | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R7
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr) |=> pend_q);

  // R6
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pend_q);

  // R5
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7) |=> !$rose(pend_q));

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/gia_addr_decode.sv
module gia_addr_decode
  import gia_pkg::*;
#(
  parameter int AW      = 12,
  parameter int NGROUPS = 8,
  parameter int NWORDS  = 2,
  parameter int BASE    = 'h800
) (
  input  logic [AW-1:0]         addr,
  output logic                  hit,
  output logic [GRP_W-1:0]      grp,
  output logic [WORD_IDX_W-1:0] word
);

  localparam int SPAN = NGROUPS * GRP_BYTES;

  logic [AW:0]   addr_x;
  logic [AW:0]   off_x;
  logic          in_lo;
  logic          in_hi;
  logic          aligned;
  logic          word_ok;

  always_comb begin
    addr_x  = {1'b0, addr};
    off_x   = addr_x - (AW+1)'(BASE);
    in_lo   = addr_x >= (AW+1)'(BASE);
    in_hi   = off_x < (AW+1)'(SPAN);
    aligned = (addr[1:0] == 2'b00);
    grp     = off_x[8:6];
    word    = off_x[5:2];
    word_ok = {1'b0, word} < 5'(NWORDS);
    hit     = in_lo && in_hi && aligned && word_ok;
  end

endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator
  import gia_pkg::*;
#(
  parameter int NPINS   = 64,
  parameter int NGROUPS = 8,
  parameter int AW      = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPINS-1:0]     pin_level,
  input  logic [3*NPINS-1:0]   pin_mode,
  input  logic [3*NPINS-1:0]   pin_group,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NGROUPS-1:0]   irq_line
);

  localparam int NWORDS = (NPINS + 31) / 32;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1;
  logic rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic                  rst_int_n;
  assign rst_int_n = rst_s2;

  logic                  dec_hit;
  logic [GRP_W-1:0]      dec_grp;
  logic [WORD_IDX_W-1:0] dec_word;

  gia_addr_decode #(
    .AW(AW), .NGROUPS(NGROUPS), .NWORDS(NWORDS), .BASE('h800)
  ) u_dec (
    .addr(bus_addr), .hit(dec_hit), .grp(dec_grp), .word(dec_word)
  );

  logic [GRP_W-1:0] grp_f [NPINS];
  logic [NPINS-1:0] pend;
  logic [NPINS-1:0] clr;
  logic             wr_hit;

  assign wr_hit = bus_wr && dec_hit;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic route_ok;
    assign grp_f[p]  = pin_group[3*p +: 3];
    assign route_ok  = {1'b0, grp_f[p]} < 4'(NGROUPS);
    assign clr[p]    = wr_hit && (grp_f[p] == dec_grp) &&
                       (dec_word == WORD_IDX_W'(p / 32)) && bus_wdata[p % 32];

    gia_pin_cell u_cell (
      .clk(clk), .rst_n(rst_int_n), .lvl(pin_level[p]),
      .mode(pin_mode[3*p +: 3]), .route_ok(route_ok),
      .clr(clr[p]), .pend(pend[p])
    );
  end

  for (genvar g = 0; g < NGROUPS; g++) begin : g_line
    logic any_set;
    always_comb begin
      any_set = 1'b0;
      for (int p = 0; p < NPINS; p++) begin
        if (grp_f[p] == GRP_W'(g) && pend[p]) any_set = 1'b1;
      end
    end
    assign irq_line[g] = any_set;
  end

  // read path: next-state and register
  logic [31:0] rd_word;
  logic [31:0] rdata_d;
  logic [31:0] rdata_q;
  logic        rdata_en;

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (grp_f[p] == dec_grp && dec_word == WORD_IDX_W'(p / 32) && pend[p])
        rd_word[p % 32] = 1'b1;
    end
    rdata_en = bus_rd;
    rdata_d  = dec_hit ? rd_word : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && !dec_hit) |=> (bus_rdata == 32'h0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |=> $stable(bus_rdata));

  // R8
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones(irq_line) <= $countones(pend));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (pend == '0 && bus_rdata == 32'h0));

endmodule

// File: tb/tb_irq_group_aggregator.sv
`timescale 1ns/1ps
module tb_irq_group_aggregator;

  localparam int NP = 48;
  localparam int NG = 6;
  localparam int AW = 12;
  localparam int NW = (NP + 31) / 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     pin_level;
  logic [3*NP-1:0]   pin_mode_v;
  logic [3*NP-1:0]   pin_group_v;
  logic              bus_wr, bus_rd;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NG-1:0]     irq_line;

  logic [2:0] cfg_mode [NP];
  logic [2:0] cfg_grp  [NP];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      pin_mode_v[3*p +: 3]  = cfg_mode[p];
      pin_group_v[3*p +: 3] = cfg_grp[p];
    end
  end

  irq_group_aggregator #(.NPINS(NP), .NGROUPS(NG), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
    .pin_mode(pin_mode_v), .pin_group(pin_group_v),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line)
  );

  // behavioural reference
  bit          m_pend [NP];
  bit          m_prev [NP];
  logic [31:0] m_rdata;
  int          rcnt;
  int          n_tests = 0;
  int          n_fail  = 0;
  string       cur_req = "R1";

  function automatic bit addr_hit(input int a, output int g, output int w);
    int off;
    off = a - 'h800;
    g = off / 64;
    w = (off % 64) / 4;
    return (a >= 'h800) && (off < NG * 64) && (a % 4 == 0) && (w < NW);
  endfunction

  always @(posedge clk) begin
    int g, w, p;
    bit hit, ev, cl;
    if (!rst_n || rcnt < 2) begin
      if (!rst_n) rcnt = 0; else rcnt++;
      for (int i = 0; i < NP; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
      m_rdata = 0;
    end else begin
      hit = addr_hit(int'(bus_addr), g, w);
      if (bus_rd) begin
        m_rdata = 0;
        if (hit) for (int b = 0; b < 32; b++) begin
          p = w * 32 + b;
          if (p < NP && int'(cfg_grp[p]) == g && m_pend[p]) m_rdata[b] = 1'b1;
        end
      end
      for (int i = 0; i < NP; i++) begin
        case (int'(cfg_mode[i]))
          2: ev = pin_level[i];
          3: ev = !pin_level[i];
          4: ev = pin_level[i] && !m_prev[i];
          5: ev = !pin_level[i] && m_prev[i];
          6: ev = pin_level[i] != m_prev[i];
          default: ev = 0;
        endcase
        if (int'(cfg_grp[i]) >= NG) ev = 0;
        cl = bus_wr && hit && int'(cfg_grp[i]) == g && (i / 32) == w && bus_wdata[i % 32];
        m_pend[i] = ev || (m_pend[i] && !cl);
        m_prev[i] = pin_level[i];
      end
    end
  end

  task automatic compare();
    logic [NG-1:0] exp_irq;
    exp_irq = '0;
    for (int p = 0; p < NP; p++)
      if (int'(cfg_grp[p]) < NG && m_pend[p]) exp_irq[cfg_grp[p]] = 1'b1;
    n_tests++;
    if (irq_line !== exp_irq) begin
      n_fail++;
      $display("FAIL %s irq_line actual=%b expected=%b t=%0t", cur_req, irq_line, exp_irq, $time);
    end
    n_tests++;
    if (bus_rdata !== m_rdata) begin
      n_fail++;
      $display("FAIL %s bus_rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, m_rdata, $time);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic rd(input int a);
    bus_rd = 1'b1; bus_addr = AW'(a);
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    cyc();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic cfg(input int p, input int m, input int g);
    cfg_mode[p] = 3'(m);
    cfg_grp[p]  = 3'(g);
  endtask

  initial begin
    rst_n = 1'b0; pin_level = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    for (int p = 0; p < NP; p++) begin cfg_mode[p] = 3'd0; cfg_grp[p] = 3'd0; end
    // R1 reset state
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    rd('h800);

    // R3 level modes, R2 placement
    cur_req = "R3";
    cfg(3, 2, 1);
    pin_level[3] = 1'b1; cyc();
    pin_level[3] = 1'b0; cyc();
    cur_req = "R2";
    rd('h840); rd('h844);
    cur_req = "R6";
    wr('h840, 32'h0000_0000); rd('h840);
    wr('h840, 32'h0000_0008); rd('h840);
    cur_req = "R3";
    cfg(40, 3, 2); cyc(2);
    cur_req = "R2";
    rd('h884); rd('h880);
    cfg(40, 0, 2);
    cur_req = "R6";
    wr('h884, 32'h0000_0100); rd('h884);

    // R4 edge modes
    cur_req = "R4";
    cfg(10, 4, 0); cfg(11, 5, 0); cfg(12, 6, 0);
    cyc(2);
    pin_level[10] = 1; pin_level[11] = 1; pin_level[12] = 1; cyc(3);
    rd('h800);
    wr('h800, 32'h0000_1c00); rd('h800);
    pin_level[10] = 0; pin_level[11] = 0; pin_level[12] = 0; cyc(2);
    rd('h800);
    wr('h800, 32'hffff_ffff); cyc();

    // R5 masked and non-interrupt modes
    cur_req = "R5";
    cfg(20, 7, 3); cfg(21, 1, 3); cfg(22, 0, 3); cfg(23, 4, 7);
    pin_level[23:20] = 4'hf; cyc(2);
    pin_level[23:20] = 4'h0; cyc(2);
    rd('h8c0);
    cfg(20, 4, 3); pin_level[20] = 1; cyc();
    cfg(20, 7, 3); pin_level[20] = 0; cyc(2);
    rd('h8c0);

    // R7 event and clear at one edge
    cur_req = "R7";
    wr('h8c0, 32'hffff_ffff);
    cfg(10, 4, 0); pin_level[10] = 0; cyc();
    pin_level[10] = 1;
    wr('h800, 32'h0000_0400);
    rd('h800);

    // R11 regrouping keeps the flag
    cur_req = "R11";
    cfg(10, 0, 4); cyc();
    rd('h800); rd('h900);
    cur_req = "R8";
    cyc(2);
    cfg(10, 0, 6); cyc();
    cfg(10, 0, 4);
    wr('h900, 32'h0000_0400); cyc();

    // R9 unmapped addresses and unused positions
    cur_req = "R9";
    cfg(47, 2, 5); pin_level[47] = 1; cyc();
    rd('h800 + 5*64 + 4);
    rd('h800 + 6*64); rd('h800 + 7*64 + 4); rd('h808); rd('h7fc); rd('h801);
    wr('h800 + 6*64 + 4, 32'hffff_ffff); wr('h806, 32'hffff_ffff);
    rd('h800 + 5*64 + 4);
    pin_level[47] = 0; cfg(47, 0, 5);
    wr('h800 + 5*64 + 4, 32'h0000_8000);

    // R10 registered read that holds
    cur_req = "R10";
    cfg(5, 2, 0); pin_level[5] = 1; cyc();
    rd('h800); cyc(3);
    wr('h800, 32'h20); cyc();
    cfg(5, 0, 0); pin_level[5] = 0;

    // random traffic
    cur_req = "R8";
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0)
        for (int p = 0; p < NP; p++) cfg(p, $urandom_range(0, 7), $urandom_range(0, 7));
      for (int p = 0; p < NP; p++) if ($urandom_range(0, 7) == 0) pin_level[p] = ~pin_level[p];
      bus_rd = ($urandom_range(0, 2) == 0);
      bus_wr = ($urandom_range(0, 5) == 0);
      bus_addr = AW'('h800 + 64 * $urandom_range(0, 7) + 4 * $urandom_range(0, 3)
                 + (($urandom_range(0, 19) == 0) ? 1 : 0));
      bus_wdata = $urandom();
      cyc();
    end
    bus_rd = 0; bus_wr = 0;
    cyc(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL %s watchdog actual=running expected=finished", cur_req);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule